// File: doc/BRIEF.md
# PCI Bus Parity Unit

This block produces and checks the even parity bit of a 32-bit multiplexed PCI address/data bus together with its four command/byte-enable lines. When the local side owns the AD lines, the block registers the parity of what is on AD and CBE# and presents it on PAR one clock later. It also enables the PAR driver one clock after AD is driven, and releases it one clock after AD is released. A parked bus needs no special handling: the local side drives AD whenever its internal grant is active on an idle bus, and PAR follows one clock later.

When the local side receives, the block checks the incoming PAR in the clock after each address phase and each completed data phase. It compares PAR with the parity of the captured AD/CBE# bits. A bad address phase raises a one-clock error pulse. A bad data phase asserts PERR# in the next clock. PERR# is then driven high for one clock before its driver is released.

Top module: `pci_par_unit`

## Requirements
- R1: In every clock after rising edge k, `par_o` equals the XOR of `ad_i` and `cbe_n_i` sampled at edge k. The 37 bits AD, CBE# and PAR therefore carry an even number of ones.
- R2: `par_oe_o` equals `ad_oe_i` delayed by one clock. This covers driven address, driven read data and bus parking alike.
- R3: An address phase is the first edge with `frame_n_i` low after an edge with it high, while `ad_oe_i` is low. At the next edge `par_i` is compared. On a mismatch, `addr_perr_o` is high for exactly the one clock after that edge.
- R4: Address parity mismatches never assert `perr_n_o` or `perr_oe_o`.
- R5: A received data phase is an edge with `irdy_n_i` and `trdy_n_i` both low and `ad_oe_i` low. A `par_i` mismatch at the following edge drives `perr_n_o` low with `perr_oe_o` high during the next clock.
- R6: After the last clock of PERR# low, `perr_oe_o` stays high with `perr_n_o` high for one clock, and then drops.
- R7: A data transfer at an edge where `ad_oe_i` is high is not checked. `par_i` at the next edge has no effect on the outputs.
- R8: An edge where only one of `irdy_n_i` or `trdy_n_i` is low is not a data transfer. The `par_i` that follows it is not checked.
- R9: Consecutive bad data phases hold `perr_n_o` low in consecutive clocks without a gap.
- R10: A synchronous active-low `rst_n` clears `par_o`, `par_oe_o`, `perr_oe_o` and `addr_perr_o` to 0 and sets `perr_n_o` to 1, including in the middle of an error sequence.
- R11: Correct parity on received address and data phases produces no error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad_i | input | 32 | Address/data bus value |
| cbe_n_i | input | 4 | Command/byte-enable bus value |
| frame_n_i | input | 1 | FRAME#, active low |
| irdy_n_i | input | 1 | IRDY#, active low |
| trdy_n_i | input | 1 | TRDY#, active low |
| par_i | input | 1 | Incoming PAR |
| ad_oe_i | input | 1 | Local side drives AD in this clock |
| par_o | output | 1 | PAR value to drive |
| par_oe_o | output | 1 | PAR driver enable |
| perr_n_o | output | 1 | PERR# value to drive |
| perr_oe_o | output | 1 | PERR# driver enable |
| addr_perr_o | output | 1 | One-clock address parity error pulse |

## Verification
The bench drives inputs on the falling edge and samples outputs 1 ns after each rising edge.

- `par_o` and `par_oe_o` are checked one edge after the AD value or enable they belong to.
- `addr_perr_o` is checked one edge after the parity sample, which is two edges after the address phase.
- `perr_n_o` is checked two edges after the data transfer.
- The trailing high drive of PERR# is checked at the edge after that.

Each vector row gives the expected outputs for the edge at which that row is sampled. The incoming parity is computed from the previous row plus a "corrupt" flag, so every result is compared in the exact clock it is due.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  // Widest vector the parity helper accepts
  localparam int unsigned PAR_MAX_W = 64;

  // Bit that makes the total number of ones in {v, bit} even
  function automatic logic even_fill(input logic [PAR_MAX_W-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < PAR_MAX_W; i++) begin
      acc = acc ^ v[i];
    end
    return acc;
  endfunction

  // Parity compare: 1 when the received bit disagrees with the computed one
  function automatic logic par_mismatch(input logic got, input logic want);
    return got ^ want;
  endfunction

endpackage

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  input  logic             ad_oe_i,
  output logic             par_o,
  output logic             par_oe_o
);
  import pci_par_pkg::*;

  localparam int unsigned TOT_W = AD_W + CBE_W;
  localparam int unsigned PAD_W = PAR_MAX_W - TOT_W;

  logic cur_fill;
  logic par_q;
  logic oe_q;

  assign cur_fill = even_fill({{PAD_W{1'b0}}, ad_i, cbe_n_i});

  // Parity and its enable lag AD by one clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= cur_fill;
      oe_q  <= ad_oe_i;
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;

  // R1: driven PAR makes the previous clock's AD/CBE# plus PAR even
  a_r1_even_total: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe_o |-> ($countones({$past(ad_i), $past(cbe_n_i), par_o}) % 2 == 0));

  // R2: PAR driver released the clock after AD is released
  a_r2_release_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ad_oe_i) |-> par_oe_o);

endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic             trdy_n_i,
  input  logic             par_i,
  input  logic             ad_oe_i,
  output logic             addr_err_o,
  output logic             data_miss_o
);
  import pci_par_pkg::*;

  localparam int unsigned TOT_W = AD_W + CBE_W;
  localparam int unsigned PAD_W = PAR_MAX_W - TOT_W;

  logic frame_q;
  logic want_q;
  logic addr_pend_q;
  logic data_pend_q;
  logic addr_err_q;

  // Named events for the assertions
  logic addr_phase;
  logic data_xfer;
  logic data_rx;
  logic par_bad;
  logic addr_miss;

  assign addr_phase = !frame_n_i && frame_q && !ad_oe_i;
  assign data_xfer  = !irdy_n_i && !trdy_n_i;
  assign data_rx    = data_xfer && !ad_oe_i;
  assign par_bad    = par_mismatch(par_i, want_q);
  assign addr_miss  = addr_pend_q && par_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q     <= 1'b1;
      want_q      <= 1'b0;
      addr_pend_q <= 1'b0;
      data_pend_q <= 1'b0;
      addr_err_q  <= 1'b0;
    end else begin
      frame_q     <= frame_n_i;
      want_q      <= even_fill({{PAD_W{1'b0}}, ad_i, cbe_n_i});
      addr_pend_q <= addr_phase;
      data_pend_q <= data_rx;
      addr_err_q  <= addr_miss;
    end
  end

  assign addr_err_o  = addr_err_q;
  assign data_miss_o = data_pend_q && par_bad;

  // R3: address error is a single-clock pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_o |=> !addr_err_o);

  // R7: nothing is pending after a transfer the local side drove
  a_r7_own_data_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (data_xfer && ad_oe_i) |=> !data_miss_o);

  // R8: a wait state leaves no data check pending
  a_r8_wait_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_n_i || trdy_n_i) |=> !data_miss_o);

endmodule

// File: rtl/pci_perr_drv.sv
module pci_perr_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic miss_i,
  output logic perr_n_o,
  output logic perr_oe_o
);

  logic act_q;
  logic tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      tail_q <= 1'b0;
    end else begin
      act_q  <= miss_i;
      tail_q <= act_q;
    end
  end

  assign perr_n_o  = !act_q;
  assign perr_oe_o = act_q || tail_q;

  // R5: PERR# low is always driven
  a_r5_low_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> perr_oe_o);

  // R6: driver drops only after a clock of driven-high PERR#
  a_r6_high_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_oe_o) |-> $past(perr_n_o));

endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic             trdy_n_i,
  input  logic             par_i,
  input  logic             ad_oe_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_n_o,
  output logic             perr_oe_o,
  output logic             addr_perr_o
);

  logic data_miss;

  pci_par_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .ad_i     (ad_i),
    .cbe_n_i  (cbe_n_i),
    .ad_oe_i  (ad_oe_i),
    .par_o    (par_o),
    .par_oe_o (par_oe_o)
  );

  pci_par_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ad_i        (ad_i),
    .cbe_n_i     (cbe_n_i),
    .frame_n_i   (frame_n_i),
    .irdy_n_i    (irdy_n_i),
    .trdy_n_i    (trdy_n_i),
    .par_i       (par_i),
    .ad_oe_i     (ad_oe_i),
    .addr_err_o  (addr_perr_o),
    .data_miss_o (data_miss)
  );

  pci_perr_drv u_perr (
    .clk       (clk),
    .rst_n     (rst_n),
    .miss_i    (data_miss),
    .perr_n_o  (perr_n_o),
    .perr_oe_o (perr_oe_o)
  );

  // R4: an address error pulse never comes with PERR# low
  a_r4_addr_not_perr: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_perr_o && !$past(data_miss)) |-> perr_n_o);

endmodule

// File: tb/pci_par_unit_tb.sv
module pci_par_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        frame_n, irdy_n, trdy_n, par_in, ad_oe;
  logic        par_o, par_oe_o, perr_n_o, perr_oe_o, addr_perr_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pci_par_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n),
    .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
    .par_i(par_in), .ad_oe_i(ad_oe), .par_o(par_o), .par_oe_o(par_oe_o),
    .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o), .addr_perr_o(addr_perr_o)
  );

  // Row: {AD, CBE#, FRAME# IRDY# TRDY# AD_OE CORRUPT, exp PAR_OE ADDR_ERR PERR# PERR_OE}
  localparam int NV = 24;
  localparam logic [44:0] VEC [0:NV-1] = '{
    {32'h0000_0000, 4'hF, 5'b11100, 4'b0010},
    {32'h1000_0040, 4'h8, 5'b01100, 4'b0010},
    {32'hDEAD_BEEF, 4'h0, 5'b10001, 4'b0110},
    {32'h0000_0000, 4'hF, 5'b11101, 4'b0001},
    {32'h0000_0000, 4'hF, 5'b11100, 4'b0011},
    {32'h0000_0000, 4'hF, 5'b11100, 4'b0010},
    {32'h2000_0100, 4'h8, 5'b01100, 4'b0010},
    {32'h1234_5678, 4'h3, 5'b00000, 4'b0010},
    {32'hA5A5_0F0F, 4'h0, 5'b00001, 4'b0001},
    {32'hFFFF_0001, 4'hC, 5'b10001, 4'b0001},
    {32'h0000_0000, 4'hF, 5'b11100, 4'b0011},
    {32'h0000_0000, 4'hF, 5'b11100, 4'b0010},
    {32'h3000_0000, 4'h6, 5'b01110, 4'b1010},
    {32'h0000_0000, 4'h0, 5'b10101, 4'b0010},
    {32'h8765_4321, 4'h0, 5'b10001, 4'b0010},
    {32'h0000_0000, 4'hF, 5'b11100, 4'b0010},
    {32'h4000_0010, 4'h7, 5'b01100, 4'b0010},
    {32'hCAFE_F00D, 4'h0, 5'b10010, 4'b1010},
    {32'h0000_0000, 4'hF, 5'b11101, 4'b0010},
    {32'h0000_0000, 4'hF, 5'b11110, 4'b1010},
    {32'h0000_FFFF, 4'hA, 5'b11110, 4'b1010},
    {32'h0000_0000, 4'hF, 5'b11100, 4'b0010},
    {32'h0000_0000, 4'hF, 5'b11000, 4'b0010},
    {32'h0000_0000, 4'hF, 5'b11101, 4'b0010}
  };

  logic [35:0] prev_bits;

  function automatic logic odd_ones(input logic [35:0] v);
    return ($countones(v) % 2) == 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [3:0] c, input logic [4:0] ctl);
    @(negedge clk);
    ad      = a;
    cbe_n   = c;
    frame_n = ctl[4];
    irdy_n  = ctl[3];
    trdy_n  = ctl[2];
    ad_oe   = ctl[1];
    par_in  = odd_ones(prev_bits) ^ ctl[0];
    prev_bits = {a, c};
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    ad = '0; cbe_n = 4'hF; frame_n = 1; irdy_n = 1; trdy_n = 1; ad_oe = 0; par_in = 0;
    prev_bits = {32'h0, 4'hF};
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10 par_oe", par_oe_o, 0);
    check("R10 perr_n", perr_n_o, 1);
    check("R10 perr_oe", perr_oe_o, 0);
    check("R10 addr_perr", addr_perr_o, 0);
    check("R10 par", par_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    prev_bits = {32'h0, 4'hF};

    // Vector walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][44:13], VEC[k][12:9], VEC[k][8:4]);
      check($sformatf("R1 par row %0d", k), par_o, odd_ones(VEC[k][44:9]));
      check($sformatf("R2 par_oe row %0d", k), par_oe_o, VEC[k][3]);
      check($sformatf("R3/R4/R11 addr row %0d", k), addr_perr_o, VEC[k][2]);
      check($sformatf("R5/R7/R8/R9 perr_n row %0d", k), perr_n_o, VEC[k][1]);
      check($sformatf("R6 perr_oe row %0d", k), perr_oe_o, VEC[k][0]);
    end

    // R1: walking one across every AD and CBE# bit while driving
    for (int b = 0; b < 36; b++) begin
      logic [35:0] w;
      w = 36'd1 << b;
      apply(w[35:4], w[3:0], 5'b11110);
      check("R1 walk par", par_o, 1'b1);
      check("R2 walk par_oe", par_oe_o, 1'b1);
    end
    apply(32'hFFFF_FFFF, 4'hF, 5'b11100);
    check("R1 all ones par", par_o, 1'b0);

    // R10: reset taken in the middle of an error sequence
    apply(32'h0, 4'hF, 5'b11100);
    apply(32'h5000_0000, 4'h7, 5'b01100);
    apply(32'h0F0F_0F0F, 4'h0, 5'b10001);
    check("R3 addr before reset", addr_perr_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    ad = '0; cbe_n = 4'hF; frame_n = 1; irdy_n = 1; trdy_n = 1; ad_oe = 1;
    par_in = ~odd_ones(prev_bits);
    @(posedge clk);
    #1;
    check("R10 mid perr_n", perr_n_o, 1);
    check("R10 mid perr_oe", perr_oe_o, 0);
    check("R10 mid addr", addr_perr_o, 0);
    check("R10 mid par_oe", par_oe_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end

endmodule